// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block shapes the serial clock of an I2C master from plain system-clock cycle counts. A byte/ACK controller above it issues three kinds of one-cycle request: open a transfer (START), clock one bit, or close the transfer (STOP). The generator pulls SCL low or releases it through an open-drain enable, and raises a one-cycle launch strobe inside each low phase and a one-cycle sample strobe inside each high phase. The controller uses these strobes to change SDA and to capture the received bit.

Three 32-bit timing words set the shape. The high and low phases have independent lengths. Each phase has its own strobe offset. A lead-in delay stretches START and a bus-free delay follows STOP. The SCL line is read back through a synchroniser, and the high phase only starts counting once the line is seen high, so a slave that stretches the clock delays the sample point. The SDA enable produced here covers only the START and STOP conditions; the controller ORs its own data drive with it.

Top module: `i2c_scl_timer`

## Requirements
- R1: Out of reset, SCL and SDA are released (scl_pull_o = 0, sda_pull_o = 0), both strobes are low and ready_o is 1.
- R2: Field layout: timing_high_i[31:16] is the high-phase length and [15:0] the sample offset. timing_low_i[31:16] is the low-phase length and [15:0] the launch offset. timing_gap_i[31:16] is the bus-free length and [15:0] the START lead-in length. All values are in system clocks.
- R3: A bit request accepted while parked pulls SCL low for exactly the low-phase length, starting in the cycle after the accepting edge, and then releases SCL.
- R4: The high phase lasts the high-phase length and starts SYNC_STAGES+1 cycles after SCL is released and observed high. SCL is then pulled low again and ready_o returns to 1.
- R5: launch_o pulses once, in low-phase cycle number equal to the launch offset (counting from 0). sample_o pulses once, in counted high-phase cycle number equal to the sample offset. An offset at or beyond its phase length gives no pulse.
- R6: While an external device holds SCL low after release, the high phase does not start, and the sample pulse and the end of the bit move later by the same number of cycles.
- R7: A START request is taken only when idle. SDA is then pulled with SCL released for the lead-in length. After that, SCL is pulled low and ready_o rises, and SDA stays pulled until the first bit begins.
- R8: A STOP request taken while parked does the following: it pulls SDA with SCL low for the low-phase length, then releases SCL, then keeps SDA pulled for the high-phase length after SCL is seen high, and then releases SDA.
- R9: After SDA is released at the end of a STOP, ready_o stays 0 for the bus-free length. A START request in that window is ignored.
- R10: A lead-in or bus-free field of 0 means 48 (0x30) clocks. A high or low length of 0 acts as 1.
- R11: Requests that arrive when ready_o is 0 are ignored. While parked, a START request is ignored, and STOP wins over a simultaneous bit request. While idle, a bit request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_high_i | input | 32 | High-phase length and sample offset |
| timing_low_i | input | 32 | Low-phase length and launch offset |
| timing_gap_i | input | 32 | Bus-free length and START lead-in length |
| start_req_i | input | 1 | Open a transfer (START) |
| bit_req_i | input | 1 | Clock one bit |
| stop_req_i | input | 1 | Close the transfer (STOP) |
| scl_i | input | 1 | Sensed SCL line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (open drain) |
| sda_pull_o | output | 1 | 1 pulls SDA low for START/STOP conditions |
| sample_o | output | 1 | One-cycle receive sample strobe |
| launch_o | output | 1 | One-cycle transmit launch strobe |
| ready_o | output | 1 | Block idle or parked and able to take a request |

## Verification
The assertions assume that scl_i follows the open-drain line, so it can read high only while scl_pull_o is 0. They also assume that the timing words are changed only while ready_o is 1. The bench meets both assumptions. It models the line as released-and-not-stretched, and it writes the timing words only between requests. Stretching is injected only while the generator itself has released SCL.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int FIELD_W = 16;
  localparam int WORD_W  = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEADIN, ST_PARK, ST_LOW, ST_WAIT_HI, ST_HIGH,
    ST_STOP_LOW, ST_STOP_WAIT, ST_STOP_HIGH, ST_FREE
  } scl_state_e;

  typedef struct packed {
    logic [FIELD_W-1:0] hi_len;
    logic [FIELD_W-1:0] rx_off;
    logic [FIELD_W-1:0] lo_len;
    logic [FIELD_W-1:0] tx_off;
    logic [FIELD_W-1:0] free_len;
    logic [FIELD_W-1:0] lead_len;
  } scl_cfg_t;
endpackage

// File: rtl/i2c_scl_cfg.sv
module i2c_scl_cfg
  import i2c_scl_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DEF_GAP = 16'h0030
) (
  input  logic [WORD_W-1:0] word_high_i,
  input  logic [WORD_W-1:0] word_low_i,
  input  logic [WORD_W-1:0] word_gap_i,
  output scl_cfg_t          cfg_o
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  function automatic logic [FIELD_W-1:0] or_alt(input logic [FIELD_W-1:0] v,
                                                input logic [FIELD_W-1:0] alt);
    return (v == '0) ? alt : v;
  endfunction

  always_comb begin
    cfg_o.hi_len   = or_alt(word_high_i[WORD_W-1:FIELD_W], ONE);
    cfg_o.rx_off   = word_high_i[FIELD_W-1:0];
    cfg_o.lo_len   = or_alt(word_low_i[WORD_W-1:FIELD_W], ONE);
    cfg_o.tx_off   = word_low_i[FIELD_W-1:0];
    cfg_o.free_len = or_alt(word_gap_i[WORD_W-1:FIELD_W], DEF_GAP);
    cfg_o.lead_len = or_alt(word_gap_i[FIELD_W-1:0], DEF_GAP);
  end
endmodule

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES:0] chain;
  assign chain[0] = line_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[i+1] <= 1'b1;  // idle bus reads high
      else         chain[i+1] <= chain[i];
    end
  end

  assign line_o = chain[STAGES];
endmodule

// File: rtl/i2c_scl_cnt.sv
module i2c_scl_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] off_i,
  output logic         last_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;  // saturate in waiting states
  end

  assign last_o = cnt_inc >= {1'b0, len_i};
  assign hit_o  = cnt_q == off_i;
endmodule

// File: rtl/i2c_scl_seq.sv
module i2c_scl_seq
  import i2c_scl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  scl_cfg_t cfg_i,
  input  logic     start_req_i,
  input  logic     bit_req_i,
  input  logic     stop_req_i,
  input  logic     scl_seen_i,
  output logic     scl_pull_o,
  output logic     sda_pull_o,
  output logic     sample_o,
  output logic     launch_o,
  output logic     ready_o
);
  scl_state_e         state_q, state_d;
  logic [FIELD_W-1:0] ph_len, ph_off;
  logic               cnt_last, cnt_hit, hold_q;

  always_comb begin
    ph_len = cfg_i.lo_len;
    ph_off = cfg_i.tx_off;
    unique case (state_q)
      ST_LEADIN:               ph_len = cfg_i.lead_len;
      ST_HIGH, ST_STOP_HIGH: begin
        ph_len = cfg_i.hi_len;
        ph_off = cfg_i.rx_off;
      end
      ST_FREE:                 ph_len = cfg_i.free_len;
      default: ;
    endcase
  end

  i2c_scl_cnt #(.W(FIELD_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .len_i  (ph_len),
    .off_i  (ph_off),
    .last_o (cnt_last),
    .hit_o  (cnt_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_req_i) state_d = ST_LEADIN;
      ST_LEADIN:    if (cnt_last)    state_d = ST_PARK;
      ST_PARK: begin
        if (stop_req_i)              state_d = ST_STOP_LOW;
        else if (bit_req_i)          state_d = ST_LOW;
      end
      ST_LOW:       if (cnt_last)    state_d = ST_WAIT_HI;
      ST_WAIT_HI:   if (scl_seen_i)  state_d = ST_HIGH;
      ST_HIGH:      if (cnt_last)    state_d = ST_PARK;
      ST_STOP_LOW:  if (cnt_last)    state_d = ST_STOP_WAIT;
      ST_STOP_WAIT: if (scl_seen_i)  state_d = ST_STOP_HIGH;
      ST_STOP_HIGH: if (cnt_last)    state_d = ST_FREE;
      ST_FREE:      if (cnt_last)    state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LEADIN && state_d == ST_PARK) hold_q <= 1'b1;
      else if (state_d == ST_LOW || state_d == ST_STOP_LOW) hold_q <= 1'b0;
    end
  end

  assign scl_pull_o = state_q inside {ST_PARK, ST_LOW, ST_STOP_LOW};
  assign sda_pull_o = (state_q inside {ST_LEADIN, ST_STOP_LOW, ST_STOP_WAIT, ST_STOP_HIGH})
                    || (state_q == ST_PARK && hold_q);
  assign launch_o   = (state_q == ST_LOW) && cnt_hit;
  assign sample_o   = (state_q == ST_HIGH) && cnt_hit;
  assign ready_o    = state_q inside {ST_IDLE, ST_PARK};

  // R6
  hi_after_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HIGH && $past(state_q) == ST_WAIT_HI) ||
     (state_q == ST_STOP_HIGH && $past(state_q) == ST_STOP_WAIT)) |-> $past(scl_seen_i));

  // R9
  free_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FREE) |-> (!scl_pull_o && !sda_pull_o && !ready_o));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [FIELD_W-1:0] DEF_GAP     = 16'h0030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] timing_high_i,
  input  logic [WORD_W-1:0] timing_low_i,
  input  logic [WORD_W-1:0] timing_gap_i,
  input  logic              start_req_i,
  input  logic              bit_req_i,
  input  logic              stop_req_i,
  input  logic              scl_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic              sample_o,
  output logic              launch_o,
  output logic              ready_o
);
  scl_cfg_t cfg;
  logic     scl_seen;

  i2c_scl_cfg #(.DEF_GAP(DEF_GAP)) u_cfg (
    .word_high_i (timing_high_i),
    .word_low_i  (timing_low_i),
    .word_gap_i  (timing_gap_i),
    .cfg_o       (cfg)
  );

  i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (scl_i),
    .line_o (scl_seen)
  );

  i2c_scl_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .start_req_i (start_req_i),
    .bit_req_i   (bit_req_i),
    .stop_req_i  (stop_req_i),
    .scl_seen_i  (scl_seen),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .sample_o    (sample_o),
    .launch_o    (launch_o),
    .ready_o     (ready_o)
  );

  // R5
  sample_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !scl_pull_o);

  // R5
  launch_pulled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> scl_pull_o);

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, launch_o}));

  // R7
  start_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_i && ready_o && !scl_pull_o) |=> (sda_pull_o && !scl_pull_o && !ready_o));

  // R9
  stop_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_pull_o) && !scl_pull_o) |-> !ready_o);
endmodule

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
  localparam int SYNC = 2;
  localparam int DLY  = SYNC + 1;
  localparam int NV   = 6;
  // hi_len, rx_off, lo_len, tx_off, stretch cycles
  localparam int VEC [NV][5] = '{
    '{6, 4, 5, 1, 0},
    '{10, 7, 8, 2, 0},
    '{3, 2, 3, 0, 0},
    '{4, 9, 4, 5, 0},
    '{0, 0, 0, 0, 0},
    '{6, 4, 5, 1, 3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] t_hi = '0, t_lo = '0, t_gap = '0;
  logic        start_r = 1'b0, bit_r = 1'b0, stop_r = 1'b0, stretch = 1'b0;
  logic        scl_pull, sda_pull, sample, launch, ready, scl_line;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  assign scl_line = !(scl_pull || stretch);

  i2c_scl_timer #(.SYNC_STAGES(SYNC)) u_i2c_scl_timer (
    .clk_i (clk), .rst_ni (rst_n),
    .timing_high_i (t_hi), .timing_low_i (t_lo), .timing_gap_i (t_gap),
    .start_req_i (start_r), .bit_req_i (bit_r), .stop_req_i (stop_r),
    .scl_i (scl_line),
    .scl_pull_o (scl_pull), .sda_pull_o (sda_pull),
    .sample_o (sample), .launch_o (launch), .ready_o (ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_bit(input int hi, input int rx, input int lo, input int tx, input int k);
    int hi_e, lo_e, low_n, launch_t, sample_t, ready_t, nl, ns, sda0;
    bit rel;
    hi_e = (hi == 0) ? 1 : hi;
    lo_e = (lo == 0) ? 1 : lo;
    t_hi = {16'(hi), 16'(rx)};
    t_lo = {16'(lo), 16'(tx)};
    @(negedge clk); bit_r = 1'b1;
    @(negedge clk); bit_r = 1'b0;
    low_n = 0; rel = 0; launch_t = -1; sample_t = -1; ready_t = -1; nl = 0; ns = 0;
    sda0 = int'(sda_pull);
    for (int t = 0; t < 600 && ready_t < 0; t++) begin
      stretch = (t < lo_e + k);
      if (scl_pull && !rel) low_n++; else rel = 1;
      if (launch) begin nl++; if (launch_t < 0) launch_t = t; end
      if (sample) begin ns++; if (sample_t < 0) sample_t = t; end
      if (ready) ready_t = t;
      else @(negedge clk);
    end
    stretch = 1'b0;
    chk(low_n == lo_e, "R3 low width", low_n, lo_e);
    chk(launch_t == ((tx < lo_e) ? tx : -1) && nl <= 1, "R5 launch", launch_t,
        (tx < lo_e) ? tx : -1);
    chk(sample_t == ((rx < hi_e) ? lo_e + DLY + k + rx : -1) && ns <= 1,
        (k > 0) ? "R6 sample" : "R5 sample", sample_t,
        (rx < hi_e) ? lo_e + DLY + k + rx : -1);
    chk(ready_t == lo_e + DLY + k + hi_e, (hi == 0) ? "R10 bit end" : "R4 bit end",
        ready_t, lo_e + DLY + k + hi_e);
    chk(sda0 == 0, "R7 sda freed at bit", sda0, 0);
  endtask

  task automatic run_start(input int lead_e, input string req);
    int lead_n, ready_t;
    @(negedge clk); start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    lead_n = 0; ready_t = -1;
    for (int t = 0; t < 600 && ready_t < 0; t++) begin
      if (sda_pull && !scl_pull) lead_n++;
      if (ready) ready_t = t;
      else @(negedge clk);
    end
    chk(lead_n == lead_e && ready_t == lead_e, req, ready_t, lead_e);
    chk(scl_pull && sda_pull, "R7 parked after start", int'({scl_pull, sda_pull}), 3);
  endtask

  task automatic run_stop(input int hi_e, input int lo_e, input int gap_e,
                          input bit with_bit, input string req);
    int rel_t, ready_t, low_n;
    @(negedge clk); stop_r = 1'b1; bit_r = with_bit;
    @(negedge clk); stop_r = 1'b0; bit_r = 1'b0;
    chk(sda_pull && scl_pull, with_bit ? "R11 stop wins" : "R8 stop low",
        int'({sda_pull, scl_pull}), 3);
    rel_t = -1; ready_t = -1; low_n = 0;
    for (int t = 0; t < 900 && ready_t < 0; t++) begin
      start_r = (t == lo_e + DLY + hi_e + 1);  // lands inside bus-free window
      if (scl_pull) low_n++;
      if (!sda_pull && rel_t < 0) rel_t = t;
      if (ready) ready_t = t;
      else @(negedge clk);
    end
    start_r = 1'b0;
    chk(low_n == lo_e, "R8 stop scl low", low_n, lo_e);
    chk(rel_t == lo_e + DLY + hi_e, "R8 sda release", rel_t, lo_e + DLY + hi_e);
    chk(ready_t == rel_t + gap_e, req, ready_t, rel_t + gap_e);
    repeat (3) @(negedge clk);
    chk(!sda_pull && !scl_pull && ready, "R9 start in free ignored",
        int'({sda_pull, scl_pull, ready}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull && !sample && !launch && ready, "R1 reset",
        int'({scl_pull, sda_pull, sample, launch, ready}), 1);
    rst_n = 1'b1;
    t_hi = {16'd6, 16'd4}; t_lo = {16'd5, 16'd1};
    t_gap = {16'd7, 16'd5};  // R2: bus-free upper, lead-in lower
    @(negedge clk);
    bit_r = 1'b1;
    repeat (3) @(negedge clk);
    bit_r = 1'b0;
    chk(!scl_pull && ready, "R11 bit in idle ignored", int'({scl_pull, ready}), 1);
    run_start(5, "R2 lead-in");
    for (int i = 0; i < NV; i++) run_bit(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
    @(negedge clk); start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    repeat (2) @(negedge clk);
    chk(scl_pull && ready && !sda_pull, "R11 start in park ignored",
        int'({scl_pull, ready, sda_pull}), 6);
    run_stop(6, 5, 7, 1'b1, "R9 bus-free");
    t_gap = '0;
    run_start(48, "R10 default lead-in");
    run_stop(6, 5, 48, 1'b0, "R10 default bus-free");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule